// File: doc/BRIEF.md
# Ring Protocol Frame Classifier

This block watches the receive byte stream of an Ethernet switch port and decides, early in each frame, whether the frame belongs to the ring redundancy protocol. It walks through up to two stacked VLAN tags. The tag EtherTypes are programmable, and each one is enabled or disabled per ingress port. It then compares the type field found behind the tags against the programmed ring EtherType. Ring frames are steered to the top priority queue. When the host port receives a copy of a ring frame, the host receive DMA channel to use is reported with the result.

An external destination-address lookup supplies, with the first byte of each frame, a hit flag, a ring-unicast flag, a VLAN member mask and a destination port mask. The classifier combines these with the ingress port to form the egress port mask. A ring-unicast hit is flooded to the VLAN members other than the ingress and host ports, whatever kind of frame carries it. One result is produced per frame as a single-cycle pulse, as soon as the deciding type field has arrived, which is well before the payload ends.

Top module: `rfc_ring_classifier`

## Requirements
- R1: While cfg_ring_en is 0, every frame is reported with cls_ring = 0.
- R2: A frame whose type at bytes 12..13 equals cfg_vlan_a, with bit [rx_port] of cfg_port_a_en set, and whose type at bytes 16..17 equals cfg_ring_type, is a ring frame. A frame whose bytes 12..13 equal the ring type with no tag in front is not a ring frame. Each type field is big-endian: the earlier byte is the high byte.
- R3: A frame whose type at bytes 12..13 equals cfg_vlan_b, with bit [rx_port] of cfg_port_b_en set, and whose type at bytes 16..17 equals cfg_ring_type, is a ring frame.
- R4: A frame with an enabled cfg_vlan_a tag at bytes 12..13, an enabled cfg_vlan_b tag at bytes 16..17 and cfg_ring_type at bytes 20..21 is a ring frame. Any other ordering of two tags (for example b then a) is not.
- R5: A tag type whose per-port enable bit for the ingress port is 0 is not recognised as a tag, so the frame is not a ring frame.
- R6: cls_queue is 3 for a ring frame and 0 for any other frame.
- R7: cls_chan_vld is 1 and cls_chan equals cfg_host_chan exactly when the frame is a ring frame and bit 0 (the host port) of cls_egress is set. Otherwise cls_chan_vld and cls_chan are 0.
- R8: When lk_hit and lk_ring_uni are both 1, cls_egress equals lk_member with the ingress bit and the host bit cleared, and cls_flood is 1. This holds whatever lk_dest holds and whether or not the frame is a ring frame.
- R9: cfg_host_uni_flood has no effect on the egress mask of a ring-unicast hit.
- R10: On a lookup hit without the ring-unicast flag, cls_egress equals lk_dest without the ingress bit. On a miss, cls_egress equals lk_member without the ingress bit, and the host bit is kept only when cfg_host_uni_flood is 1. cls_flood is 0 in both cases.
- R11: cls_valid pulses exactly once per frame, one cycle after the byte that decides: byte 13, 17 or 21 for a decision at a type field, or the last byte of a frame that ends before its deciding field. A frame cut short in this way is not a ring frame. Bytes after the decision produce no further pulse.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Byte beat present |
| rx_sof | input | 1 | Beat is byte 0 of a frame |
| rx_eof | input | 1 | Beat is the last byte of a frame |
| rx_data | input | 8 | Frame byte |
| rx_port | input | 2 | Ingress port number, 0 is the host port |
| lk_hit | input | 1 | Destination lookup found an entry |
| lk_ring_uni | input | 1 | Matched entry carries the ring-unicast flag |
| lk_member | input | 3 | VLAN member port mask |
| lk_dest | input | 3 | Destination port mask of the matched entry |
| cfg_ring_en | input | 1 | Global ring classification enable |
| cfg_vlan_a | input | 16 | First VLAN tag EtherType |
| cfg_vlan_b | input | 16 | Second VLAN tag EtherType |
| cfg_port_a_en | input | 3 | Per-port enable for cfg_vlan_a |
| cfg_port_b_en | input | 3 | Per-port enable for cfg_vlan_b |
| cfg_ring_type | input | 16 | Ring protocol EtherType |
| cfg_host_chan | input | 3 | Host receive DMA channel for ring frames |
| cfg_host_uni_flood | input | 1 | Include host in unknown-unicast flooding |
| cls_valid | output | 1 | One-cycle result strobe |
| cls_ring | output | 1 | Frame is a ring frame |
| cls_queue | output | 2 | Egress priority queue |
| cls_egress | output | 3 | Egress port mask |
| cls_flood | output | 1 | Ring-unicast flood applied |
| cls_chan_vld | output | 1 | cls_chan applies |
| cls_chan | output | 3 | Host receive DMA channel |

## Verification
The assertions assume that the configuration inputs and the lookup inputs stay unchanged while a frame is in progress, that the lookup result is present with the first byte, and that rx_port always names an existing port. Under these assumptions the ring-enable check and the egress checks can compare against live inputs. The stimulus changes configuration and lookup values only between frames and draws ports from 0 to 2. Frame bytes are random, but the three type positions are biased toward the programmed tag and ring EtherTypes, so that every path through the tag walk and every early-end case appears often.

// File: rtl/rfc_pkg.sv
// Shared constants and types of the ring frame classifier.
package rfc_pkg;
    // Byte offset of the first EtherType and the size of one VLAN tag.
    localparam int TYPE_BASE  = 12;
    localparam int TAG_BYTES  = 4;
    // Number of type fields the walker may inspect (untagged + two tags).
    localparam int MAX_FIELDS = 3;
    localparam int ETYPE_W    = 16;

    localparam logic [1:0] RING_QUEUE = 2'd3;
    localparam logic [1:0] BASE_QUEUE = 2'd0;

    // Tag walk position inside a frame.
    typedef enum logic [2:0] {
        WK_IDLE,     // decided or between frames
        WK_FIRST,    // waiting for type field 0
        WK_AFTER_A,  // saw enabled tag A, waiting for type field 1
        WK_AFTER_B,  // saw enabled tag B, waiting for type field 1
        WK_THIRD     // saw A then B, waiting for type field 2
    } walk_t;
endpackage

// File: rtl/rfc_byte_tracker.sv
// Byte position tracker.
// Counts bytes of the current frame and presents each 16-bit type word
// on the beat of its low byte, with a one-hot strobe naming which field.
// Assumes rx_sof marks byte 0; the counter saturates on long frames.
module rfc_byte_tracker
    import rfc_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int FIELDS = MAX_FIELDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic [7:0]         in_data,
    output logic [ETYPE_W-1:0] type_word,
    output logic [FIELDS-1:0]  field_hit
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] beat_idx;
    logic [7:0]       prev_q;

    assign beat_idx  = in_sof ? '0 : cnt_q;
    assign type_word = {prev_q, in_data};

    // Advance the byte index, saturating past the last inspected field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (in_valid) begin
            cnt_q <= (beat_idx == IDX_MAX) ? IDX_MAX : beat_idx + 1'b1;
        end
    end

    // Hold the previous byte as the high half of the next type word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else if (in_valid) begin
            prev_q <= in_data;
        end
    end

    // One strobe per type field, on the beat of its low byte.
    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        assign field_hit[g] = in_valid &&
                              (beat_idx == IDX_W'(TYPE_BASE + 1 + g * TAG_BYTES));
    end
endmodule

// File: rtl/rfc_tag_walker.sv
// VLAN tag walker.
// Follows up to two stacked, per-port-enabled tags and decides ring or
// non-ring on the deciding type field, or non-ring at an early frame end.
// Assumes configuration inputs are stable for the duration of a frame.
module rfc_tag_walker
    import rfc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sof,
    input  logic                  in_eof,
    input  logic [MAX_FIELDS-1:0] field_hit,
    input  logic [ETYPE_W-1:0]    type_word,
    input  logic                  ring_en,
    input  logic [ETYPE_W-1:0]    vlan_a,
    input  logic [ETYPE_W-1:0]    vlan_b,
    input  logic [ETYPE_W-1:0]    ring_type,
    input  logic                  a_en,
    input  logic                  b_en,
    output logic                  dec_valid,
    output logic                  dec_ring
);
    walk_t st_q, st_cur, st_nxt;
    logic  is_a, is_b, is_ring;

    // Compare the current type word against the programmed types.
    always_comb begin
        is_a    = a_en && (type_word == vlan_a);
        is_b    = b_en && (type_word == vlan_b);
        is_ring = (type_word == ring_type);
    end

    // Step the walk and raise a decision on the deciding beat.
    always_comb begin
        st_cur    = (in_valid && in_sof) ? WK_FIRST : st_q;
        st_nxt    = st_cur;
        dec_valid = 1'b0;
        dec_ring  = 1'b0;
        if (in_valid) begin
            unique case (st_cur)
                WK_FIRST: begin
                    if (field_hit[0]) begin
                        if (ring_en && is_a)      st_nxt = WK_AFTER_A;
                        else if (ring_en && is_b) st_nxt = WK_AFTER_B;
                        else                      dec_valid = 1'b1;
                    end
                end
                WK_AFTER_A: begin
                    if (field_hit[1]) begin
                        if (is_ring) begin
                            dec_valid = 1'b1;
                            dec_ring  = 1'b1;
                        end else if (is_b) begin
                            st_nxt = WK_THIRD;
                        end else begin
                            dec_valid = 1'b1;
                        end
                    end
                end
                WK_AFTER_B: begin
                    if (field_hit[1]) begin
                        dec_valid = 1'b1;
                        dec_ring  = is_ring;
                    end
                end
                WK_THIRD: begin
                    if (field_hit[2]) begin
                        dec_valid = 1'b1;
                        dec_ring  = is_ring;
                    end
                end
                default: ;
            endcase
            if (!dec_valid && in_eof && (st_cur != WK_IDLE)) begin
                dec_valid = 1'b1;
            end
            if (dec_valid) begin
                st_nxt = WK_IDLE;
            end
        end
    end

    // Walk state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= WK_IDLE;
        else        st_q <= st_nxt;
    end

    // R1: a ring verdict only while classification is enabled.
    a_r1_ring_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_ring) |-> ring_en);

    // R4: a ring verdict only on the beat of a tagged type field.
    a_r4_ring_on_tagged_field: assert property (@(posedge clk) disable iff (!rst_n)
        dec_ring |-> (field_hit[1] || field_hit[2]));
endmodule

// File: rtl/rfc_egress_resolver.sv
// Egress mask resolver.
// Forms the egress port mask from the lookup result and the ingress port.
// A ring-unicast hit floods to members minus ingress and host, ignoring
// the destination mask and the host unknown-unicast enable.
module rfc_egress_resolver #(
    parameter int NUM_PORTS = 3,
    parameter int HOST_PORT = 0
) (
    input  logic [NUM_PORTS-1:0] ingress_mask,
    input  logic                 lk_hit,
    input  logic                 lk_ring_uni,
    input  logic [NUM_PORTS-1:0] lk_member,
    input  logic [NUM_PORTS-1:0] lk_dest,
    input  logic                 host_uni_flood,
    output logic [NUM_PORTS-1:0] egress,
    output logic                 flood
);
    localparam logic [NUM_PORTS-1:0] HOST_MASK = NUM_PORTS'(1) << HOST_PORT;

    // Pick the forwarding rule for this frame.
    always_comb begin
        flood = 1'b0;
        if (lk_hit && lk_ring_uni) begin
            flood  = 1'b1;
            egress = lk_member & ~ingress_mask & ~HOST_MASK;
        end else if (lk_hit) begin
            egress = lk_dest & ~ingress_mask;
        end else begin
            egress = lk_member & ~ingress_mask & ~(host_uni_flood ? '0 : HOST_MASK);
        end
    end
endmodule

// File: rtl/rfc_ring_classifier.sv
// Ring protocol frame classifier (top).
// Captures ingress port and lookup result at frame start, walks the tags,
// and registers a one-cycle classification result after the deciding byte.
// Assumes rx_port < NUM_PORTS and lookup/config inputs stable per frame.
module rfc_ring_classifier
    import rfc_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int HOST_PORT = 0,
    parameter int CHAN_CNT  = 8,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int CHAN_W   = (CHAN_CNT > 1) ? $clog2(CHAN_CNT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic                 rx_sof,
    input  logic                 rx_eof,
    input  logic [7:0]           rx_data,
    input  logic [PORT_W-1:0]    rx_port,
    input  logic                 lk_hit,
    input  logic                 lk_ring_uni,
    input  logic [NUM_PORTS-1:0] lk_member,
    input  logic [NUM_PORTS-1:0] lk_dest,
    input  logic                 cfg_ring_en,
    input  logic [ETYPE_W-1:0]   cfg_vlan_a,
    input  logic [ETYPE_W-1:0]   cfg_vlan_b,
    input  logic [NUM_PORTS-1:0] cfg_port_a_en,
    input  logic [NUM_PORTS-1:0] cfg_port_b_en,
    input  logic [ETYPE_W-1:0]   cfg_ring_type,
    input  logic [CHAN_W-1:0]    cfg_host_chan,
    input  logic                 cfg_host_uni_flood,
    output logic                 cls_valid,
    output logic                 cls_ring,
    output logic [1:0]           cls_queue,
    output logic [NUM_PORTS-1:0] cls_egress,
    output logic                 cls_flood,
    output logic                 cls_chan_vld,
    output logic [CHAN_W-1:0]    cls_chan
);
    localparam int IDX_W = $clog2(TYPE_BASE + TAG_BYTES * (MAX_FIELDS - 1) + 2) + 1;

    logic                  sof_beat;
    logic [PORT_W-1:0]     port_q, port_cur;
    logic                  hit_q, runi_q, hit_cur, runi_cur;
    logic [NUM_PORTS-1:0]  mem_q, dest_q, mem_cur, dest_cur;
    logic [NUM_PORTS-1:0]  ingress_mask, egress;
    logic                  flood;
    logic [ETYPE_W-1:0]    type_word;
    logic [MAX_FIELDS-1:0] field_hit;
    logic                  dec_valid, dec_ring, chan_hit;

    assign sof_beat = rx_valid && rx_sof;

    // Capture per-frame context on the first byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
            hit_q  <= 1'b0;
            runi_q <= 1'b0;
            mem_q  <= '0;
            dest_q <= '0;
        end else if (sof_beat) begin
            port_q <= rx_port;
            hit_q  <= lk_hit;
            runi_q <= lk_ring_uni;
            mem_q  <= lk_member;
            dest_q <= lk_dest;
        end
    end

    // Use live context on the first byte, captured context afterwards.
    always_comb begin
        port_cur     = sof_beat ? rx_port     : port_q;
        hit_cur      = sof_beat ? lk_hit      : hit_q;
        runi_cur     = sof_beat ? lk_ring_uni : runi_q;
        mem_cur      = sof_beat ? lk_member   : mem_q;
        dest_cur     = sof_beat ? lk_dest     : dest_q;
        ingress_mask = NUM_PORTS'(1) << port_cur;
    end

    rfc_byte_tracker #(
        .IDX_W  (IDX_W),
        .FIELDS (MAX_FIELDS)
    ) i_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .in_sof    (rx_sof),
        .in_data   (rx_data),
        .type_word (type_word),
        .field_hit (field_hit)
    );

    rfc_tag_walker i_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .in_sof    (rx_sof),
        .in_eof    (rx_eof),
        .field_hit (field_hit),
        .type_word (type_word),
        .ring_en   (cfg_ring_en),
        .vlan_a    (cfg_vlan_a),
        .vlan_b    (cfg_vlan_b),
        .ring_type (cfg_ring_type),
        .a_en      (cfg_port_a_en[port_cur]),
        .b_en      (cfg_port_b_en[port_cur]),
        .dec_valid (dec_valid),
        .dec_ring  (dec_ring)
    );

    rfc_egress_resolver #(
        .NUM_PORTS (NUM_PORTS),
        .HOST_PORT (HOST_PORT)
    ) i_resolver (
        .ingress_mask   (ingress_mask),
        .lk_hit         (hit_cur),
        .lk_ring_uni    (runi_cur),
        .lk_member      (mem_cur),
        .lk_dest        (dest_cur),
        .host_uni_flood (cfg_host_uni_flood),
        .egress         (egress),
        .flood          (flood)
    );

    assign chan_hit = dec_ring && egress[HOST_PORT];

    // Register the classification result on the decision beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_valid    <= 1'b0;
            cls_ring     <= 1'b0;
            cls_queue    <= BASE_QUEUE;
            cls_egress   <= '0;
            cls_flood    <= 1'b0;
            cls_chan_vld <= 1'b0;
            cls_chan     <= '0;
        end else begin
            cls_valid <= dec_valid;
            if (dec_valid) begin
                cls_ring     <= dec_ring;
                cls_queue    <= dec_ring ? RING_QUEUE : BASE_QUEUE;
                cls_egress   <= egress;
                cls_flood    <= flood;
                cls_chan_vld <= chan_hit;
                cls_chan     <= chan_hit ? cfg_host_chan : '0;
            end
        end
    end

    // R8: a flooded result never targets the ingress or host port.
    a_r8_flood_excludes: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_valid && cls_flood) |->
            (!cls_egress[HOST_PORT] && ((cls_egress & (NUM_PORTS'(1) << port_q)) == '0)));

    // R7: the host channel is reported only for a ring frame sent to the host.
    a_r7_chan_needs_host: assert property (@(posedge clk) disable iff (!rst_n)
        cls_chan_vld |-> (cls_ring && cls_egress[HOST_PORT]));

    // R11: no second pulse unless a new frame starts.
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_valid && !(rx_valid && rx_sof)) |=> !cls_valid);
endmodule

// File: tb/test_rfc_ring_classifier.sv
module test_rfc_ring_classifier;
    localparam logic [15:0] VA = 16'h8100;
    localparam logic [15:0] VB = 16'h88A8;
    localparam logic [15:0] RT = 16'h80E1;
    localparam logic [15:0] XX = 16'h1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 0, rx_sof = 0, rx_eof = 0;
    logic [7:0]  rx_data = 0;
    logic [1:0]  rx_port = 0;
    logic        lk_hit = 0, lk_ring_uni = 0;
    logic [2:0]  lk_member = 0, lk_dest = 0;
    logic        cfg_ring_en = 1;
    logic [15:0] cfg_vlan_a = VA, cfg_vlan_b = VB, cfg_ring_type = RT;
    logic [2:0]  cfg_port_a_en = 3'b111, cfg_port_b_en = 3'b111;
    logic [2:0]  cfg_host_chan = 3'd5;
    logic        cfg_host_uni_flood = 0;
    logic        cls_valid, cls_ring, cls_flood, cls_chan_vld;
    logic [1:0]  cls_queue;
    logic [2:0]  cls_egress, cls_chan;

    int   nchk = 0, nfail = 0;
    logic [7:0] fb [0:63];

    always #5 clk = ~clk;

    rfc_ring_classifier i_rfc_ring_classifier (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .rx_port(rx_port),
        .lk_hit(lk_hit), .lk_ring_uni(lk_ring_uni), .lk_member(lk_member),
        .lk_dest(lk_dest), .cfg_ring_en(cfg_ring_en), .cfg_vlan_a(cfg_vlan_a),
        .cfg_vlan_b(cfg_vlan_b), .cfg_port_a_en(cfg_port_a_en),
        .cfg_port_b_en(cfg_port_b_en), .cfg_ring_type(cfg_ring_type),
        .cfg_host_chan(cfg_host_chan), .cfg_host_uni_flood(cfg_host_uni_flood),
        .cls_valid(cls_valid), .cls_ring(cls_ring), .cls_queue(cls_queue),
        .cls_egress(cls_egress), .cls_flood(cls_flood),
        .cls_chan_vld(cls_chan_vld), .cls_chan(cls_chan)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected decision beat and verdict, from the tag rules.
    function automatic void model(input int n, output int didx, output bit ring);
        int st = 1;
        logic [15:0] w;
        ring = 0;
        didx = n - 1;
        for (int k = 0; k < 3; k++) begin
            int hi = 13 + 4 * k;
            if (n - 1 < hi) begin didx = n - 1; return; end
            w = {fb[hi-1], fb[hi]};
            didx = hi;
            case (st)
                1: if (cfg_ring_en && w == cfg_vlan_a && cfg_port_a_en[rx_port]) st = 2;
                   else if (cfg_ring_en && w == cfg_vlan_b && cfg_port_b_en[rx_port]) st = 3;
                   else return;
                2: if (w == cfg_ring_type) begin ring = 1; return; end
                   else if (w == cfg_vlan_b && cfg_port_b_en[rx_port]) st = 4;
                   else return;
                default: begin ring = (w == cfg_ring_type); return; end
            endcase
            if (n - 1 == hi) return;
        end
    endfunction

    // Expected egress mask and flood flag.
    function automatic void egress_model(output logic [2:0] eg, output bit fl);
        logic [2:0] ing = 3'b001 << rx_port;
        fl = 0;
        if (lk_hit && lk_ring_uni) begin
            eg = lk_member & ~ing & ~3'b001; fl = 1;
        end else if (lk_hit) begin
            eg = lk_dest & ~ing;
        end else begin
            eg = lk_member & ~ing & ~(cfg_host_uni_flood ? 3'b000 : 3'b001);
        end
    endfunction

    task automatic make_frame(input int n, input logic [15:0] t0,
                              input logic [15:0] t1, input logic [15:0] t2);
        for (int i = 0; i < 64; i++) fb[i] = 8'($urandom);
        {fb[12], fb[13]} = t0;
        {fb[16], fb[17]} = t1;
        {fb[20], fb[21]} = t2;
        if (n < 0) ;
    endtask

    task automatic run_frame(input int n, input string rtag, input string etag);
        int didx, pulses = 0, seen = -1;
        bit ering, efl, cv;
        logic [2:0] eeg;
        bit g_ring = 0, g_fl = 0, g_cv = 0;
        logic [1:0] g_q = 0;
        logic [2:0] g_eg = 0, g_ch = 0;
        model(n, didx, ering);
        egress_model(eeg, efl);
        cv = ering && eeg[0];
        for (int i = 0; i <= n + 1; i++) begin
            @(negedge clk);
            if (i > 0 && cls_valid) begin
                pulses++; seen = i - 1;
                g_ring = cls_ring; g_q = cls_queue; g_eg = cls_egress;
                g_fl = cls_flood; g_cv = cls_chan_vld; g_ch = cls_chan;
            end
            if (i < n) begin
                rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == n - 1); rx_data = fb[i];
            end else begin
                rx_valid = 0; rx_sof = 0; rx_eof = 0;
            end
        end
        check(pulses == 1, "R11", "pulse count", pulses, 1);
        check(seen == didx, "R11", "decision beat", seen, didx);
        check(g_ring == ering, rtag, "ring verdict", g_ring, ering);
        check(g_q == (ering ? 2'd3 : 2'd0), "R6", "queue", g_q, ering ? 3 : 0);
        check(g_eg == eeg && g_fl == efl, etag, "egress/flood", {g_fl, g_eg}, {efl, eeg});
        check(g_cv == cv && g_ch == (cv ? cfg_host_chan : 3'd0), "R7", "host channel",
              {g_cv, g_ch}, {cv, (cv ? cfg_host_chan : 3'd0)});
    endtask

    task automatic set_lk(input logic [1:0] p, input bit h, input bit ru,
                          input logic [2:0] m, input logic [2:0] d);
        rx_port = p; lk_hit = h; lk_ring_uni = ru; lk_member = m; lk_dest = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12: outputs cleared by reset
        check({cls_valid, cls_ring, cls_queue, cls_egress, cls_flood, cls_chan_vld, cls_chan} == '0,
              "R12", "reset outputs",
              {cls_valid, cls_ring, cls_queue, cls_egress, cls_flood, cls_chan_vld, cls_chan}, 0);

        set_lk(2'd1, 1, 0, 3'b111, 3'b100);
        make_frame(30, RT, RT, RT); run_frame(30, "R2", "R10");   // untagged ring type
        make_frame(30, VA, RT, XX); run_frame(30, "R2", "R10");
        make_frame(30, VB, RT, XX); run_frame(30, "R3", "R10");
        make_frame(30, VA, VB, RT); run_frame(30, "R4", "R10");
        make_frame(30, VB, VA, RT); run_frame(30, "R4", "R10");
        cfg_port_a_en = 3'b101;
        make_frame(30, VA, RT, XX); run_frame(30, "R5", "R10");
        cfg_port_a_en = 3'b111; cfg_ring_en = 0;
        make_frame(30, VA, RT, XX); run_frame(30, "R1", "R10");
        cfg_ring_en = 1;
        make_frame(16, VA, RT, XX); run_frame(16, "R11", "R10");  // ends before byte 17
        make_frame(19, VA, VB, RT); run_frame(19, "R11", "R10");  // ends before byte 21
        set_lk(2'd2, 1, 1, 3'b111, 3'b001); cfg_host_uni_flood = 1;
        make_frame(30, VA, RT, XX); run_frame(30, "R2", "R9");
        cfg_host_uni_flood = 0;
        make_frame(30, VA, RT, XX); run_frame(30, "R2", "R9");
        make_frame(30, XX, XX, XX); run_frame(30, "R2", "R8");    // non-ring still floods
        set_lk(2'd2, 1, 0, 3'b111, 3'b011);
        make_frame(30, VA, RT, XX); run_frame(30, "R7", "R10");
        set_lk(2'd1, 0, 0, 3'b111, 3'b000); cfg_host_uni_flood = 1;
        make_frame(30, VA, RT, XX); run_frame(30, "R7", "R10");
        cfg_host_uni_flood = 0;
        make_frame(30, VA, RT, XX); run_frame(30, "R10", "R10");

        for (int f = 0; f < 300; f++) begin
            logic [15:0] t [3];
            int n;
            if (f % 10 == 0) begin
                cfg_ring_en        = ($urandom % 8) != 0;
                cfg_port_a_en      = 3'($urandom);
                cfg_port_b_en      = 3'($urandom);
                cfg_host_uni_flood = 1'($urandom);
                cfg_host_chan      = 3'($urandom);
            end
            for (int k = 0; k < 3; k++) begin
                case ($urandom % 5)
                    0: t[k] = VA;
                    1: t[k] = VB;
                    2: t[k] = RT;
                    default: t[k] = 16'($urandom);
                endcase
            end
            n = 8 + int'($urandom % 33);
            set_lk(2'($urandom % 3), 1'($urandom), 1'($urandom), 3'($urandom), 3'($urandom));
            make_frame(n, t[0], t[1], t[2]);
            run_frame(n, "R4", "R8");
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule